// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial engine behind an SPI master. A chip-select manager hands it one right-justified transmit word together with the settings for the selected peripheral: clock idle level, clock phase, an encoded word length, a baud divisor, a delay from select to the first clock edge, and a delay after the word. The engine then generates the serial clock, shifts the word out most-significant bit first on the data output, samples the data input on the opposite edge, and returns the received bits right-justified. An optional internal loopback sends the engine's own output into the receive path in place of the data input.

A transfer starts through a valid/ready handshake. `start_ready` is high only while the engine is idle and the divisor is 2 or more. A word is taken on any clock edge where `start_valid` and `start_ready` are both high. The transmit word, configuration and loopback select are captured on that edge. The requester must hold `start_valid` and its data until that happens. The result side has no back-pressure. `done` pulses for one clock, and `rx_data` keeps its value until the next `done`.

Top module: `spi_master_serializer`

## Requirements
- R1: `start_ready` is high exactly when the engine is idle and `cfg_div` is at least 2. A transfer is accepted on a clock edge where `start_valid` and `start_ready` are both high. `busy` is high from the cycle after acceptance through the end of the trailing delay, and `start_ready` stays low during that time.
- R2: With `cfg_div` at 0 or 1 the clock generator is off. `start_valid` is ignored, `busy` and `done` stay low, and `spck` rests at `cfg_cpol`.
- R3: While idle, `spck` equals `cfg_cpol`. During a transfer of n bits it makes exactly 2n transitions, each `cfg_div` clocks after the one before, and it finishes at its idle level.
- R4: The word length n is 8 plus the 4-bit `cfg_bits` code, for codes 0 to 8 (8 to 16 bits). Codes above 8 act as 16 bits.
- R5: Bits are sent most-significant first, starting at bit n-1 of `tx_word`. Bits of `tx_word` at n and above have no effect.
- R6: With `cfg_ncpha`=1, data is captured on leading clock edges (odd-numbered transitions counting from 1) and changed on trailing edges. With `cfg_ncpha`=0, data changes on leading edges and is captured on trailing edges. In both modes `mosi` holds bit n-1 from acceptance until the first edge.
- R7: The first `spck` transition comes `cfg_lead` clocks after the accepting edge, or `cfg_div` clocks when `cfg_lead` is 0.
- R8: `done` rises L + `cfg_div`*(2n-1) + T clocks after the accepting edge. Here L is the delay from R7, and T is 32*`cfg_trail`, or 4 when `cfg_trail` is 0.
- R9: With loopback off, `rx_data` holds the n bits sampled from `miso`, first-sampled bit at n-1, right-justified, with bits n and above at 0.
- R10: With `loopback`=1, `rx_data` equals the low n bits of `tx_word`, whatever `miso` does.
- R11: `done` is high for exactly one clock, and `busy` is low in that clock. `rx_data` changes only together with `done`.
- R12: During and right after reset, `busy`, `done` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Requester offers a word |
| start_ready | output | 1 | Engine can accept a word |
| tx_word | input | 16 | Right-justified transmit word |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_ncpha | input | 1 | 1: capture on leading edge; 0: capture on trailing edge |
| cfg_bits | input | 4 | Word length code (length = 8 + code) |
| cfg_div | input | 8 | Half-period of the serial clock in master clocks; 0 or 1 disables |
| cfg_lead | input | 8 | Select-to-first-edge delay in clocks (0: one half-period) |
| cfg_trail | input | 8 | Trailing delay in units of 32 clocks (0: 4 clocks) |
| loopback | input | 1 | Route own serial output into the receive path |
| miso | input | 1 | Serial data input |
| spck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |
| rx_data | output | 16 | Right-justified received word |

## Verification
All timing is counted from the clock edge that accepts the start. `busy` is due one cycle after that edge. The first `spck` transition is due L cycles after it, and each later transition follows `cfg_div` cycles after the one before. `done` is due L + `cfg_div`*(2n-1) + T cycles after acceptance, with `rx_data` valid in the same cycle. The bench drives the handshake and counts master-clock cycles from that edge, sampling on falling edges. It acts as a slave that updates `miso` only after change edges and records `mosi` at capture edges. It then compares the edge count, the edge spacing, the cycle of each event, and the captured and received words against values computed from the formulas above.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;
  localparam int DATA_W = 16;
  localparam int BITS_W = 4;
  localparam int DIV_W  = 8;
  localparam int DLY_W  = 8;

  // settings held for the duration of one word
  typedef struct packed {
    logic             cpol;
    logic             ncpha;
    logic [DIV_W-1:0] div;
    logic [DLY_W-1:0] trail;
  } xfer_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } ser_state_e;
endpackage

// File: rtl/spi_ser_timer.sv
module spi_ser_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_ser_edges.sv
module spi_ser_edges #(
  parameter int NBITS_W = 5,
  parameter int EDGE_W  = NBITS_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               idle_level,
  input  logic               step,
  input  logic [NBITS_W-1:0] nbits,
  output logic               spck,
  output logic               lead,
  output logic               last
);
  logic [EDGE_W-1:0] cnt_q;
  logic              spck_q;
  logic [EDGE_W-1:0] total_edges;

  assign total_edges = {nbits, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      spck_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      spck_q <= idle_level;
    end else if (step) begin
      cnt_q  <= cnt_q + EDGE_W'(1);
      spck_q <= ~spck_q;
    end
  end

  assign spck = spck_q;
  assign lead = ~cnt_q[0];
  assign last = (cnt_q == total_edges - EDGE_W'(1));

  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q < total_edges));
endmodule

// File: rtl/spi_ser_shifter.sv
module spi_ser_shifter #(
  parameter int DATA_W  = 16,
  parameter int NBITS_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DATA_W-1:0]  tx_word,
  input  logic [NBITS_W-1:0] nbits,
  input  logic               ncpha,
  input  logic               step,
  input  logic               capture,
  input  logic               in_bit,
  output logic               mosi,
  output logic [DATA_W-1:0]  rx_word
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [IDX_W-1:0]  idx_q;
  logic              mosi_q;
  logic [IDX_W-1:0]  top_idx;

  assign top_idx = IDX_W'(nbits - NBITS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      idx_q  <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_word;
      rx_q   <= '0;
      idx_q  <= top_idx;
      mosi_q <= tx_word[top_idx];
    end else if (step) begin
      if (capture) begin
        rx_q <= {rx_q[DATA_W-2:0], in_bit};
      end else if (ncpha) begin
        // change on trailing edge: move to the following bit
        if (idx_q != '0) begin
          mosi_q <= tx_q[idx_q - IDX_W'(1)];
          idx_q  <= idx_q - IDX_W'(1);
        end
      end else begin
        // change on leading edge: present the current bit
        mosi_q <= tx_q[idx_q];
        if (idx_q != '0) idx_q <= idx_q - IDX_W'(1);
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_q;

  // R9
  rx_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && capture && !load) |=> (rx_q[0] == $past(in_bit)));
endmodule

// File: rtl/spi_master_serializer.sv
module spi_master_serializer #(
  parameter int MIN_BITS      = 8,
  parameter int TRAIL_SCALE   = 32,
  parameter int TRAIL_DEFAULT = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_valid,
  output logic                             start_ready,
  input  logic [spi_ser_pkg::DATA_W-1:0]   tx_word,
  input  logic                             cfg_cpol,
  input  logic                             cfg_ncpha,
  input  logic [spi_ser_pkg::BITS_W-1:0]   cfg_bits,
  input  logic [spi_ser_pkg::DIV_W-1:0]    cfg_div,
  input  logic [spi_ser_pkg::DLY_W-1:0]    cfg_lead,
  input  logic [spi_ser_pkg::DLY_W-1:0]    cfg_trail,
  input  logic                             loopback,
  input  logic                             miso,
  output logic                             spck,
  output logic                             mosi,
  output logic                             busy,
  output logic                             done,
  output logic [spi_ser_pkg::DATA_W-1:0]   rx_data
);
  import spi_ser_pkg::*;

  localparam int NBITS_W   = $clog2(DATA_W + 1);
  localparam int EDGE_W    = NBITS_W + 1;
  localparam int TRAIL_MAX = TRAIL_SCALE * ((1 << DLY_W) - 1);
  localparam int CNT_RAW   = $clog2(TRAIL_MAX + 1);
  localparam int CNT_W     = (CNT_RAW > DIV_W) ? CNT_RAW : DIV_W;

  ser_state_e         state_q, state_d;
  xfer_cfg_t          cfg_q;
  logic [NBITS_W-1:0] nbits_in, nbits_q;
  logic [NBITS_W:0]   len_sum;
  logic               loop_q;
  logic               accept;
  logic               div_ok;
  logic               tmr_load, tmr_zero;
  logic [CNT_W-1:0]   tmr_val, lead_ld, half_ld, trail_ld;
  logic               edge_ev, fin;
  logic               edge_lead, edge_last, capture;
  logic               spck_int, mosi_int, in_bit;
  logic [DATA_W-1:0]  rx_word;
  logic               done_q;
  logic [DATA_W-1:0]  rx_q;

  // word length from the encoded field, saturated at the data width
  always_comb begin
    len_sum = (NBITS_W+1)'(MIN_BITS) + (NBITS_W+1)'(cfg_bits);
    if (len_sum > (NBITS_W+1)'(DATA_W)) nbits_in = NBITS_W'(DATA_W);
    else                                 nbits_in = len_sum[NBITS_W-1:0];
  end

  assign div_ok      = (cfg_div >= DIV_W'(2));
  assign start_ready = (state_q == ST_IDLE) && div_ok;
  assign accept      = start_valid && start_ready;

  assign lead_ld  = (cfg_lead == '0) ? (CNT_W'(cfg_div) - CNT_W'(1))
                                     : (CNT_W'(cfg_lead) - CNT_W'(1));
  assign half_ld  = CNT_W'(cfg_q.div) - CNT_W'(1);
  assign trail_ld = (cfg_q.trail == '0) ? CNT_W'(TRAIL_DEFAULT - 1)
                                        : (CNT_W'(TRAIL_SCALE * cfg_q.trail) - CNT_W'(1));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = half_ld;
    edge_ev  = 1'b0;
    fin      = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_LEAD;
        tmr_load = 1'b1;
        tmr_val  = lead_ld;
      end
      ST_LEAD: if (tmr_zero) begin
        edge_ev  = 1'b1;
        state_d  = ST_SHIFT;
        tmr_load = 1'b1;
      end
      ST_SHIFT: if (tmr_zero) begin
        edge_ev  = 1'b1;
        tmr_load = 1'b1;
        if (edge_last) begin
          state_d = ST_TRAIL;
          tmr_val = trail_ld;
        end
      end
      ST_TRAIL: if (tmr_zero) begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      nbits_q <= NBITS_W'(MIN_BITS);
      loop_q  <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept) begin
        cfg_q.cpol  <= cfg_cpol;
        cfg_q.ncpha <= cfg_ncpha;
        cfg_q.div   <= cfg_div;
        cfg_q.trail <= cfg_trail;
        nbits_q     <= nbits_in;
        loop_q      <= loopback;
      end
      if (fin) rx_q <= rx_word;
    end
  end

  spi_ser_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  spi_ser_edges #(.NBITS_W(NBITS_W), .EDGE_W(EDGE_W)) u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .idle_level (cfg_cpol),
    .step       (edge_ev),
    .nbits      (nbits_q),
    .spck       (spck_int),
    .lead       (edge_lead),
    .last       (edge_last)
  );

  assign capture = (edge_lead == cfg_q.ncpha);
  assign in_bit  = loop_q ? mosi_int : miso;

  spi_ser_shifter #(.DATA_W(DATA_W), .NBITS_W(NBITS_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .tx_word (tx_word),
    .nbits   (nbits_in),
    .ncpha   (cfg_q.ncpha),
    .step    (edge_ev),
    .capture (capture),
    .in_bit  (in_bit),
    .mosi    (mosi_int),
    .rx_word (rx_word)
  );

  assign busy    = (state_q != ST_IDLE);
  assign spck    = busy ? spck_int : cfg_cpol;
  assign mosi    = mosi_int;
  assign done    = done_q;
  assign rx_data = rx_q;

  // R1
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ready);

  // R2
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_valid && (cfg_div < DIV_W'(2))) |=> !busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_data));

  // R3
  spck_rests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spck_int == cfg_q.cpol));
endmodule

// File: tb/sim_spi_master_serializer.sv
`timescale 1ns/1ps
module sim_spi_master_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] tx_word = '0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_ncpha = 1'b0;
  logic [3:0]  cfg_bits = '0;
  logic [7:0]  cfg_div = '0;
  logic [7:0]  cfg_lead = '0;
  logic [7:0]  cfg_trail = '0;
  logic        loopback = 1'b0;
  logic        miso = 1'b0;
  logic        spck, mosi, busy, done;
  logic [15:0] rx_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_master_serializer u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .tx_word(tx_word), .cfg_cpol(cfg_cpol), .cfg_ncpha(cfg_ncpha), .cfg_bits(cfg_bits),
    .cfg_div(cfg_div), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .loopback(loopback),
    .miso(miso), .spck(spck), .mosi(mosi), .busy(busy), .done(done), .rx_data(rx_data)
  );

  typedef struct packed {
    logic        cpol;
    logic        ncpha;
    logic [3:0]  code;
    logic [7:0]  div;
    logic [7:0]  lead;
    logic [7:0]  trail;
    logic        lb;
    logic [15:0] tx;
    logic [15:0] sl;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'd0,  8'd2,   8'd0, 8'd0, 1'b0, 16'h00A5, 16'h003C},
    '{1'b1, 1'b0, 4'd8,  8'd3,   8'd5, 8'd1, 1'b0, 16'hC3E1, 16'h5AF0},
    '{1'b0, 1'b0, 4'd4,  8'd2,   8'd1, 8'd0, 1'b1, 16'hF9B6, 16'h0FFF},
    '{1'b1, 1'b1, 4'd1,  8'd4,   8'd0, 8'd2, 1'b0, 16'h0155, 16'h01AA},
    '{1'b0, 1'b1, 4'd7,  8'd2,   8'd3, 8'd0, 1'b1, 16'h8001, 16'h1234},
    '{1'b1, 1'b0, 4'd2,  8'd255, 8'd0, 8'd0, 1'b0, 16'h02C7, 16'h0339},
    '{1'b0, 1'b0, 4'd13, 8'd2,   8'd2, 8'd0, 1'b1, 16'hABCD, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic run_vec(input vec_t v);
    int n, mask, L, T, exp_done, exp_rx;
    int cyc, edges, first, last_t, bad_gap, mword, idx;
    bit got_done, prev;
    logic [15:0] rx_hold;
    n        = 8 + ((v.code > 4'd8) ? 8 : int'(v.code));
    mask     = (1 << n) - 1;
    L        = (v.lead == 0) ? int'(v.div) : int'(v.lead);
    T        = (v.trail == 0) ? 4 : 32 * int'(v.trail);
    exp_done = L + int'(v.div) * (2 * n - 1) + T;
    exp_rx   = v.lb ? (int'(v.tx) & mask) : (int'(v.sl) & mask);

    @(negedge clk);
    cfg_cpol = v.cpol; cfg_ncpha = v.ncpha; cfg_bits = v.code; cfg_div = v.div;
    cfg_lead = v.lead; cfg_trail = v.trail; loopback = v.lb; tx_word = v.tx;
    miso = v.sl[n-1];
    start_valid = 1'b1;
    #1;
    chk(start_ready == 1'b1, "R1 ready idle", int'(start_ready), 1);
    chk(spck == v.cpol, "R3 idle level", int'(spck), int'(v.cpol));
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy == 1'b1 && start_ready == 1'b0, "R1 busy after accept",
        int'({busy, start_ready}), 2);
    chk(mosi == v.tx[n-1], "R6 first bit before edge", int'(mosi), int'(v.tx[n-1]));

    cyc = 0; edges = 0; first = -1; last_t = 0; bad_gap = 0; mword = 0;
    got_done = 1'b0; prev = spck;
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (spck != prev) begin
        if (first < 0) first = cyc;
        else if (cyc - last_t != int'(v.div)) bad_gap++;
        last_t = cyc;
        if (((edges % 2) == 0) == v.ncpha) begin
          mword = (mword << 1) | int'(mosi);
        end else begin
          idx = v.ncpha ? (n - 1 - ((edges + 1) >> 1)) : (n - 1 - (edges >> 1));
          if (idx >= 0) miso = v.sl[idx];
        end
        edges++;
        prev = spck;
      end
      if (done) got_done = 1'b1;
    end

    chk(got_done, "R8 done seen", int'(got_done), 1);
    chk(first == L, "R7 lead delay", first, L);
    chk(edges == 2 * n, "R3 edge count", edges, 2 * n);
    chk(bad_gap == 0, "R3 edge spacing", bad_gap, 0);
    chk(mword == (int'(v.tx) & mask), "R5 R6 serial out word", mword, int'(v.tx) & mask);
    chk(cyc == exp_done, "R8 done timing", cyc, exp_done);
    if (v.lb) chk(int'(rx_data) == exp_rx, "R10 loopback word", int'(rx_data), exp_rx);
    else      chk(int'(rx_data) == exp_rx, "R9 received word", int'(rx_data), exp_rx);
    chk(busy == 1'b0, "R11 busy low with done", int'(busy), 0);
    chk(spck == v.cpol, "R3 ends idle", int'(spck), int'(v.cpol));
    rx_hold = rx_data;
    miso = ~miso;
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
    chk(rx_data == rx_hold, "R11 rx holds", int'(rx_data), int'(rx_hold));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R12: outputs during and after reset
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R12 reset busy/done", int'({busy, done}), 0);
    chk(rx_data == 16'h0, "R12 reset rx", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rx_data == 16'h0, "R12 after reset",
        int'({busy, done}), 0);
    chk(start_ready == 1'b0, "R2 ready low with div 0", int'(start_ready), 0);

    // table-driven transfers: R4 word lengths, R5..R10 data paths
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: divisor 0 and 1 disable the generator
    for (int d = 0; d < 2; d++) begin
      bit any_busy, any_done, any_ready, any_move;
      any_busy = 0; any_done = 0; any_ready = 0; any_move = 0;
      @(negedge clk);
      cfg_cpol = 1'b1; cfg_div = 8'(d); cfg_lead = 8'd0; start_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy) any_busy = 1;
        if (done) any_done = 1;
        if (start_ready) any_ready = 1;
        if (spck != 1'b1) any_move = 1;
      end
      start_valid = 1'b0;
      chk(!any_busy, "R2 no busy when disabled", int'(any_busy), 0);
      chk(!any_done, "R2 no done when disabled", int'(any_done), 0);
      chk(!any_ready, "R2 ready low when disabled", int'(any_ready), 0);
      chk(!any_move, "R2 spck rests at idle", int'(any_move), 0);
    end

    summary();
    $finish;
  end
endmodule